// File: doc/BRIEF.md
# Write Pulse Filter and Page-Load Timer

This block sits on the device side of a parallel EEPROM, behind the byte-wide host bus. It oversamples the active-low write strobe and the chip-select and output-enable controls on a fast internal clock. It discards write strobes that are too short or badly framed. Each strobe that survives places one byte into a page buffer. The byte's slot in the buffer comes from the low address bits.

The block does not wait for an explicit command to close a page. A retriggerable byte-load timer does that job. Every return of the write strobe to high restarts the timer. A new falling strobe halts it, so the next byte joins the same page. If the timer runs out, a one-cycle program strobe is issued with the buffered page. Busy then stays high for the whole write cycle, and the buffer is emptied for the next page. Strobes are also refused for a fixed settling interval after reset.

The default parameters assume a 5 ns sampling clock. All durations are clock-cycle counts. The cell programmer must take the page contents in the program-strobe cycle.

Top module: `pwc_top`

## Requirements
- R1: A write strobe whose synchronized low time is shorter than MIN_PULSE_CYC clock cycles loads no byte. A strobe of exactly MIN_PULSE_CYC cycles is accepted.
- R2: A strobe is accepted when it lasts long enough, chip select is low, output enable is high and the block is neither inhibited nor busy. An accepted strobe stores the data byte in slot `addr[SLOT_W-1:0]`, which is field `prog_data[slot*DW +: DW]`, and sets `prog_mask[slot]`.
- R3: If chip select is high, or output enable is low, in any sampled cycle of the strobe's low phase, the strobe is rejected.
- R4: Every rising write strobe restarts the byte-load timer while at least one byte is pending or the strobe itself was accepted. This includes rejected short strobes. `prog_start` is high for exactly one cycle, in the cycle after the (BLC_CYC+3)th rising clock edge that follows the strobe's rise. In other words, it is first seen at the (BLC_CYC+3)th falling clock edge after the rise.
- R5: A falling write strobe before expiry stops the timer, and the bytes of successive strobes collect into one page.
- R6: For INIT_CYC cycles after reset, every write strobe is ignored.
- R7: `busy` rises together with `prog_start` and stays high for exactly TWC_CYC cycles.
- R8: Strobes that arrive while busy are ignored. One cycle after `prog_start`, the mask and the data are zero.
- R9: `prog_page` holds the upper address bits `addr[AW-1:SLOT_W]` of the most recently accepted byte, and it is valid in the strobe cycle.
- R10: After reset, `prog_start`, `busy`, `prog_mask` and `prog_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Asynchronous write strobe, active low |
| ce_n | input | 1 | Asynchronous chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Byte address from the host |
| din | input | DW | Write data from the host |
| prog_start | output | 1 | One-cycle strobe that starts programming of the page |
| busy | output | 1 | High during the internal write cycle |
| prog_page | output | AW-SLOT_W | Page address of the buffered bytes |
| prog_mask | output | PAGE_BYTES | One bit per loaded slot |
| prog_data | output | PAGE_BYTES*DW | Page buffer contents, slot 0 in the low bits |

## Verification
A fault in the width counter or the framing flag shows up as a wrong `prog_mask` about three cycles after the strobe rises. A timer that fails to restart, or does not stop, moves `prog_start` away from its exact cycle, and the error is seen within BLC_CYC+3 cycles of the last rise. A slot decoder or capture register that is off points shows wrong bytes or a wrong page in the strobe cycle. A fault in the clearing or busy logic shows as a nonzero mask after the strobe, a busy window of the wrong length, or a second, unwanted program strobe.

// File: rtl/pwc_pkg.sv
// Shared types for the page-write controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwc_pkg;
    // Write-strobe events seen on the synchronized strobe
    typedef struct packed {
        logic fall;   // strobe went low this cycle
        logic rise;   // strobe went high this cycle
        logic good;   // pulse that just ended was wide enough and well framed
    } we_evt_t;
endpackage

// File: rtl/pwc_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: multi-bit buses are stable while they are sampled (only the
// single-bit controls need true metastability protection).
module pwc_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages toward the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pwc_pulse_qual.sv
// Measures each low phase of the synchronized write strobe. A pulse is
// marked good when it lasted at least MIN_PULSE_CYC cycles, with chip select
// low and output enable high in every cycle. Address and data from the last
// low cycle are held for capture at the rise.
// Assumes: inputs already synchronized and aligned to one another.
module pwc_pulse_qual
    import pwc_pkg::*;
#(
    parameter int MIN_PULSE_CYC = 4,
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_s,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] din_s,
    output we_evt_t       evt,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_din
);
    localparam int CW = $clog2(MIN_PULSE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE_CYC);

    logic          we_d;
    logic [CW-1:0] wcnt;
    logic          frame_ok;
    logic          sel_ok;

    assign sel_ok = ~ce_s & oe_s;

    // Track the low phase: saturating width count, framing flag, bus hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_d     <= 1'b1;
            wcnt     <= '0;
            frame_ok <= 1'b0;
            cap_addr <= '0;
            cap_din  <= '0;
        end else begin
            we_d <= we_s;
            if (!we_s) begin
                cap_addr <= addr_s;
                cap_din  <= din_s;
                if (we_d) begin
                    wcnt     <= CW'(1);
                    frame_ok <= sel_ok;
                end else begin
                    if (wcnt != CMAX) wcnt <= wcnt + CW'(1);
                    frame_ok <= frame_ok & sel_ok;
                end
            end
        end
    end

    // Edge and quality decode
    always_comb begin
        evt.fall = we_d & ~we_s;
        evt.rise = ~we_d & we_s;
        evt.good = frame_ok & (wcnt >= CMAX);
    end
endmodule

// File: rtl/pwc_page_buf.sv
// Page buffer: one byte register and one valid bit per slot, plus the page
// address of the last loaded byte. A clear empties it.
// Assumes: PAGE_BYTES is a power of two and at least 2.
module pwc_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [AW-1:0]                load_addr,
    input  logic [DW-1:0]                load_data,
    input  logic                         clr,
    output logic [PAGE_BYTES-1:0]        mask,
    output logic [PAGE_BYTES*DW-1:0]     data,
    output logic [AW-$clog2(PAGE_BYTES)-1:0] page
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_AW = AW - SLOT_W;

    logic [SLOT_W-1:0] slot;
    assign slot = load_addr[SLOT_W-1:0];

    // Page address register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) page <= '0;
        else if (load)     page <= load_addr[AW-1:SLOT_W];
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Per-slot byte store and valid flag
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                mask[g]            <= 1'b0;
                data[g*DW +: DW]   <= '0;
            end else if (load && slot == SLOT_W'(g)) begin
                mask[g]            <= 1'b1;
                data[g*DW +: DW]   <= load_data;
            end
        end
    end

    logic unused_w;
    assign unused_w = ^PAGE_AW;
endmodule

// File: rtl/pwc_sequencer.sv
// Power-up inhibit, retriggerable byte-load timer and write-cycle busy timer.
// Decides byte acceptance and issues the one-cycle program strobe.
// Assumes: BLC_CYC >= 2, TWC_CYC >= 1, INIT_CYC >= 1.
module pwc_sequencer
    import pwc_pkg::*;
#(
    parameter int BLC_CYC  = 20000,
    parameter int TWC_CYC  = 1000000,
    parameter int INIT_CYC = 2000000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  we_evt_t evt,
    input  logic    pending,
    output logic    accept,
    output logic    prog_start,
    output logic    busy
);
    localparam int TW = $clog2(BLC_CYC);
    localparam int BW = $clog2(TWC_CYC + 1);
    localparam int IW = $clog2(INIT_CYC + 1);

    logic [IW-1:0] icnt;
    logic          inhibit;
    logic          run;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bcnt;
    logic          gate;

    assign inhibit = (icnt != IW'(INIT_CYC));
    assign gate    = ~busy & ~inhibit;
    assign accept  = evt.rise & evt.good & gate;

    // Post-reset inhibit counter
    always_ff @(posedge clk) begin
        if (!rst_n)       icnt <= '0;
        else if (inhibit) icnt <= icnt + IW'(1);
    end

    // Byte-load timer, program strobe and busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            tcnt       <= '0;
            prog_start <= 1'b0;
            busy       <= 1'b0;
            bcnt       <= '0;
        end else begin
            prog_start <= 1'b0;
            if (busy) begin
                if (bcnt == '0) busy <= 1'b0;
                else            bcnt <= bcnt - BW'(1);
            end
            if (gate && evt.fall) begin
                run <= 1'b0;
            end else if (gate && evt.rise && (pending || accept)) begin
                run  <= 1'b1;
                tcnt <= '0;
            end else if (run) begin
                if (tcnt == TW'(BLC_CYC - 1)) begin
                    run        <= 1'b0;
                    prog_start <= 1'b1;
                    busy       <= 1'b1;
                    bcnt       <= BW'(TWC_CYC - 1);
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwc_top.sv
// Write-pulse filter and page-load timer of a parallel EEPROM.
// Synchronizes the host controls, qualifies write strobes, fills the page
// buffer and commits the page when the byte-load timer runs out.
// Assumes: defaults sized for a 5 ns sampling clock; address and data held
// stable around the write strobe's rising edge.
module pwc_top #(
    parameter int AW            = 15,
    parameter int DW            = 8,
    parameter int PAGE_BYTES    = 64,
    parameter int MIN_PULSE_CYC = 4,
    parameter int BLC_CYC       = 20000,
    parameter int TWC_CYC       = 1000000,
    parameter int INIT_CYC      = 2000000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_n,
    input  logic                             ce_n,
    input  logic                             oe_n,
    input  logic [AW-1:0]                    addr,
    input  logic [DW-1:0]                    din,
    output logic                             prog_start,
    output logic                             busy,
    output logic [AW-$clog2(PAGE_BYTES)-1:0] prog_page,
    output logic [PAGE_BYTES-1:0]            prog_mask,
    output logic [PAGE_BYTES*DW-1:0]         prog_data
);
    import pwc_pkg::*;

    logic [2:0]       ctl_s;
    logic [AW+DW-1:0] bus_s;
    we_evt_t          evt;
    logic [AW-1:0]    cap_addr;
    logic [DW-1:0]    cap_din;
    logic             accept;

    pwc_sync #(.W(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({we_n, ce_n, oe_n}), .q(ctl_s)
    );

    pwc_sync #(.W(AW+DW), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
    );

    pwc_pulse_qual #(.MIN_PULSE_CYC(MIN_PULSE_CYC), .AW(AW), .DW(DW)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .we_s(ctl_s[2]), .ce_s(ctl_s[1]), .oe_s(ctl_s[0]),
        .addr_s(bus_s[AW+DW-1:DW]), .din_s(bus_s[DW-1:0]),
        .evt(evt), .cap_addr(cap_addr), .cap_din(cap_din)
    );

    pwc_sequencer #(.BLC_CYC(BLC_CYC), .TWC_CYC(TWC_CYC), .INIT_CYC(INIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .pending(|prog_mask),
        .accept(accept), .prog_start(prog_start), .busy(busy)
    );

    pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .AW(AW), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .load_addr(cap_addr), .load_data(cap_din),
        .clr(prog_start),
        .mask(prog_mask), .data(prog_data), .page(prog_page)
    );
endmodule

// File: rtl/pwc_checker.sv
// Port-level temporal checks for pwc_top, attached by bind below.
// Assumes: reset is held for at least one clock edge at start.
module pwc_checker #(
    parameter int PAGE_BYTES = 64,
    parameter int INIT_CYC   = 2000000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prog_start,
    input logic                  busy,
    input logic [PAGE_BYTES-1:0] prog_mask
);
    localparam int IW = $clog2(INIT_CYC + 1);
    logic [IW-1:0] since_rst;

    // Cycles elapsed since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rst <= '0;
        else if (since_rst != IW'(INIT_CYC)) since_rst <= since_rst + IW'(1);
    end

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    p_busy_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> busy);

    p_busy_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> prog_start);

    p_cleared_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> (prog_mask == '0));

    p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_start) |-> (prog_mask == '0));

    p_mask_only_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_start |=> ((prog_mask & $past(prog_mask)) == $past(prog_mask)));

    p_inhibit_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != IW'(INIT_CYC)) |-> (prog_mask == '0));
endmodule

bind pwc_top pwc_checker #(.PAGE_BYTES(PAGE_BYTES), .INIT_CYC(INIT_CYC)) u_pwc_checker (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .busy(busy), .prog_mask(prog_mask)
);

// File: tb/pwc_top_bench.sv
module pwc_top_bench;
    localparam int AW = 6, DW = 8, PB = 4;
    localparam int MINP = 4, BLC = 40, TWC = 60, INIT = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic prog_start, busy;
    logic [AW-3:0] prog_page;
    logic [PB-1:0] prog_mask;
    logic [PB*DW-1:0] prog_data;

    int n_tests = 0, n_fail = 0;
    int strobe_cnt = 0, busy_len = 0, last_busy_len = 0;
    int last_page = 0;
    bit finished = 1'b0;

    // Vector: len[31:24] ce[23] oe[22] accept[21] addr[13:8] data[7:0]
    localparam logic [31:0] VEC [8] = '{
        {8'd6,  1'b0, 1'b1, 1'b1, 7'd0, 6'h05, 8'hA5},  // R2 slot 1
        {8'd3,  1'b0, 1'b1, 1'b0, 7'd0, 6'h02, 8'h3C},  // R1 one short
        {8'd4,  1'b0, 1'b1, 1'b1, 7'd0, 6'h0B, 8'h5A},  // R1 exact minimum
        {8'd6,  1'b1, 1'b1, 1'b0, 7'd0, 6'h01, 8'h11},  // R3 chip select high
        {8'd6,  1'b0, 1'b0, 1'b0, 7'd0, 6'h01, 8'h22},  // R3 output enable low
        {8'd1,  1'b0, 1'b1, 1'b0, 7'd0, 6'h03, 8'h33},  // R1 glitch
        {8'd10, 1'b0, 1'b1, 1'b1, 7'd0, 6'h30, 8'hFF},  // R2 slot 0
        {8'd20, 1'b0, 1'b1, 1'b1, 7'd0, 6'h2E, 8'h01}   // R2 slot 2
    };

    pwc_top #(.AW(AW), .DW(DW), .PAGE_BYTES(PB), .MIN_PULSE_CYC(MINP),
              .BLC_CYC(BLC), .TWC_CYC(TWC), .INIT_CYC(INIT)) u_pwc_top (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .din(din), .prog_start(prog_start), .busy(busy),
        .prog_page(prog_page), .prog_mask(prog_mask), .prog_data(prog_data)
    );

    always #10 clk = ~clk;

    // Strobe count, page at strobe, and busy run length
    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_start) begin
                strobe_cnt++;
                last_page = int'(prog_page);
            end
            if (busy) busy_len++;
            else if (busy_len != 0) begin
                last_busy_len = busy_len;
                busy_len = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int len, input logic ce, input logic oe);
        @(negedge clk);
        addr = a; din = d; ce_n = ce; oe_n = oe;
        @(negedge clk);
        we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks the strobe lands exactly BLC+3 falling edges after the last rise
    task automatic expect_strobe(input string req);
        bit early = 1'b0;
        for (int k = 1; k <= BLC + 2; k++) begin
            @(negedge clk);
            if (prog_start) early = 1'b1;
        end
        chk(req, "no early strobe", int'(early), 0);
        @(negedge clk);
        chk(req, "strobe on time", int'(prog_start), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "prog_start", int'(prog_start), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "mask", int'(prog_mask), 0);
        chk("R10", "data", int'(prog_data), 0);

        // R6 strobe inside the inhibit window
        pulse(6'h01, 8'h11, 6, 1'b0, 1'b1);
        idle(6);
        chk("R6", "mask after inhibited write", int'(prog_mask), 0);
        idle(BLC + 10);
        chk("R6", "no strobe", strobe_cnt, 0);

        // Table walk: R1 R2 R3 R7 R9
        for (int i = 0; i < 8; i++) begin
            automatic logic [31:0] v = VEC[i];
            automatic int s0 = strobe_cnt;
            automatic int slot = int'(v[9:8]);
            pulse(v[13:8], v[7:0], int'(v[31:24]), v[23], v[22]);
            idle(6);
            chk(v[21] ? "R2" : "R1/R3", "mask", int'(prog_mask), v[21] ? (1 << slot) : 0);
            if (v[21]) chk("R2", "data slot", int'(prog_data[slot*DW +: DW]), int'(v[7:0]));
            idle(BLC + TWC + 10);
            chk("R4", "strobe count", strobe_cnt - s0, int'(v[21]));
            if (v[21]) begin
                chk("R9", "page", last_page, int'(v[13:10]));
                chk("R7", "busy length", last_busy_len, TWC);
            end
        end

        // R3 chip select lifted in mid-pulse
        @(negedge clk); addr = 6'h01; din = 8'h44; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        idle(3); ce_n = 1'b1; idle(2); ce_n = 1'b0; idle(3); we_n = 1'b1;
        idle(6);
        chk("R3", "mid-pulse deselect rejected", int'(prog_mask), 0);
        idle(BLC + 10);

        // R5 two bytes in one page, then R4 R9 R7 R8
        begin
            automatic int s0 = strobe_cnt;
            pulse(6'h09, 8'h77, 6, 1'b0, 1'b1);
            idle(BLC - 10);
            chk("R5", "timer stopped before expiry", strobe_cnt - s0, 0);
            pulse(6'h1E, 8'h88, 5, 1'b0, 1'b1);
            expect_strobe("R4");
            chk("R5", "merged mask", int'(prog_mask), 4'b0110);
            chk("R5", "slot1 byte", int'(prog_data[15:8]), 8'h77);
            chk("R5", "slot2 byte", int'(prog_data[23:16]), 8'h88);
            chk("R9", "page of last byte", int'(prog_page), 7);
            chk("R7", "busy at strobe", int'(busy), 1);
            @(negedge clk);
            chk("R8", "mask cleared", int'(prog_mask), 0);
            chk("R8", "data cleared", int'(prog_data), 0);
            pulse(6'h03, 8'h99, 6, 1'b0, 1'b1);
            idle(TWC + BLC + 10);
            chk("R8", "busy write ignored", int'(prog_mask), 0);
            chk("R8", "no second strobe", strobe_cnt - s0, 1);
            chk("R7", "busy length", last_busy_len, TWC);
        end

        // R4 a rejected glitch still restarts the timer
        pulse(6'h20, 8'h42, 6, 1'b0, 1'b1);
        idle(20);
        pulse(6'h21, 8'h43, 2, 1'b0, 1'b1);
        expect_strobe("R4");
        chk("R1", "glitch byte absent", int'(prog_mask), 4'b0001);
        chk("R2", "slot0 byte", int'(prog_data[7:0]), 8'h42);
        idle(TWC + 10);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule